// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory Processor Datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. A single ALU and a single word-addressed memory are reused from cycle to cycle: the same adder advances the program counter, forms branch targets, computes effective addresses and executes register-to-register operations. Values that must survive from one cycle to the next are kept in holding registers: the instruction register, two operand latches, a memory data latch and an ALU result latch.

The block makes no decisions of its own. Every multiplexer select and every write enable is a port, driven cycle by cycle by an external sequencer. The block reports back the instruction's major opcode, its function field and the ALU zero flag. A side port writes and reads the internal memory so that programs and data can be loaded and results inspected.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter is 0 and the instruction register is 0, so `opcode` and `funct` both read 0.
- R2: The memory address is the program counter when `addr_sel`=0 and the ALU result latch when `addr_sel`=1. The word index is byte address bits [MEM_AW+1:2]. Reads are combinational. When `mem_wr` is high, the operand B latch is written to that word at the clock edge.
- R3: The instruction register loads the memory read data only in cycles with `ir_wr`=1 and holds its value otherwise. `opcode` is bits [31:26] of this register and `funct` is bits [5:0].
- R4: ALU input A is the program counter when `opa_sel`=0 and the operand A latch when `opa_sel`=1.
- R5: ALU input B is selected by `opb_sel`: 0 gives the operand B latch, 1 gives the constant 4, 2 gives instruction bits [15:0] sign-extended, and 3 gives that value shifted left by two.
- R6: `alu_op` selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). Codes 5 to 7 give a result of 0. `alu_zero` is high exactly when the current result is all zeros.
- R7: The next program counter is selected by `npc_sel`: 0 takes the live ALU result, 1 takes the ALU result latch, and 2 takes the jump target. The jump target is the program counter's bits [31:28], then instruction bits [25:0], then two zero bits.
- R8: The program counter loads at a clock edge when `pc_wr` is high, or when `pc_wr_cond` is high and `alu_zero` is high. In all other cycles it holds its value.
- R9: The register file reads the entries named by instruction bits [25:21] and [20:16]. It writes when `rf_wr` is high, at the entry named by bits [20:16] when `rf_dst_sel`=0 and by bits [15:11] when `rf_dst_sel`=1. The written data is the ALU result latch when `wb_sel`=0 and the memory data latch when `wb_sel`=1.
- R10: Register 0 always reads as 0, whatever is written to it.
- R11: The operand A and B latches, the memory data latch and the ALU result latch capture new values at every clock edge, so each value is available in the following cycle.
- R12: When `pl_we` is high, `pl_wdata` is written to memory word `pl_idx`. This write takes priority over a datapath write to the same word in the same cycle. `pl_rdata` combinationally returns word `pl_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Memory address source: PC or ALU result latch |
| mem_wr | input | 1 | Write operand B latch to memory |
| ir_wr | input | 1 | Load instruction register |
| opa_sel | input | 1 | ALU input A select |
| opb_sel | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| npc_sel | input | 2 | Next program counter source |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load when ALU result is zero |
| rf_wr | input | 1 | Register file write enable |
| rf_dst_sel | input | 1 | Destination field select |
| wb_sel | input | 1 | Write-back source select |
| pl_we | input | 1 | Side-port memory write |
| pl_idx | input | MEM_AW | Side-port word index |
| pl_wdata | input | 32 | Side-port write data |
| pl_rdata | output | 32 | Side-port read data |
| opcode | output | 6 | Instruction register bits [31:26] |
| funct | output | 6 | Instruction register bits [5:0] |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The risky overlap is the conditional branch cycle. In that cycle the one ALU is busy comparing the two operand latches, and the program counter is loaded from the ALU result latch, which holds the target computed in the previous cycle. The bench arranges branches with equal and unequal operands, and with forward and backward offsets. It judges the outcome by fetching a probe word whose function field encodes its own word index, so a wrong target, a wrong condition or the wrong PC source each show up as a mismatch. A second overlap, a datapath store and a side-port write to the same word in one cycle, is provoked once and judged by reading the word back.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   localparam logic [1:0] OPB_REG   = 2'd0;
   localparam logic [1:0] OPB_FOUR  = 2'd1;
   localparam logic [1:0] OPB_IMM   = 2'd2;
   localparam logic [1:0] OPB_IMMSH = 2'd3;

   localparam logic [1:0] NPC_ALU  = 2'd0;
   localparam logic [1:0] NPC_HELD = 2'd1;
   localparam logic [1:0] NPC_JUMP = 2'd2;
endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
   parameter int W          = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   op,
   output logic [W-1:0] res,
   output logic         zero
);
   import mc_pkg::*;

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_slt_s
         assign lt = $signed(a) < $signed(b);
      end else begin : g_slt_u
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD: res = a + b;
         ALU_SUB: res = a - b;
         ALU_AND: res = a & b;
         ALU_OR:  res = a | b;
         ALU_SLT: res = {{(W-1){1'b0}}, lt};
         default: res = '0;
      endcase
   end

   assign zero = (res == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W  = 32,
   parameter int N  = 32,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  qa,
   output logic [W-1:0]  qb
);
   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (we && (wa != '0)) regs[wa] <= wd;
   end

   assign qa = (ra == '0) ? '0 : regs[ra];
   assign qb = (rb == '0) ? '0 : regs[rb];

   // R9
   rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/mc_memory.sv
module mc_memory #(
   parameter int W     = 32,
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] idx,
   input  logic          we,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rd,
   input  logic          pl_we,
   input  logic [AW-1:0] pl_idx,
   input  logic [W-1:0]  pl_wd,
   output logic [W-1:0]  pl_rd
);
   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (pl_we)   mem[pl_idx] <= pl_wd;
      else if (we) mem[idx]    <= wd;
   end

   assign rd    = mem[idx];
   assign pl_rd = mem[pl_idx];

   // R2
   mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !pl_we) |=> (mem[$past(idx)] == $past(wd)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath #(
   parameter int DATA_W     = 32,
   parameter int REGS       = 32,
   parameter int MEM_WORDS  = 64,
   parameter bit SLT_SIGNED = 1'b1,
   localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_sel,
   input  logic              mem_wr,
   input  logic              ir_wr,
   input  logic              opa_sel,
   input  logic [1:0]        opb_sel,
   input  logic [2:0]        alu_op,
   input  logic [1:0]        npc_sel,
   input  logic              pc_wr,
   input  logic              pc_wr_cond,
   input  logic              rf_wr,
   input  logic              rf_dst_sel,
   input  logic              wb_sel,
   input  logic              pl_we,
   input  logic [MEM_AW-1:0] pl_idx,
   input  logic [31:0]       pl_wdata,
   output logic [31:0]       pl_rdata,
   output logic [5:0]        opcode,
   output logic [5:0]        funct,
   output logic              alu_zero
);
   import mc_pkg::*;

   localparam int RA_W  = $clog2(REGS);
   localparam int IMM_W = 16;

   initial begin
      assert (DATA_W == 32) else $fatal(1, "field layout needs a 32-bit word");
      assert (REGS == 32) else $fatal(1, "register fields are 5 bits wide");
      assert (MEM_WORDS >= 2 && MEM_AW + 2 <= DATA_W) else $fatal(1, "bad memory depth");
   end

   logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, mdr_q, aluout_q;
   logic [DATA_W-1:0] opa, opb, alu_res, mem_addr, mem_rd, npc;
   logic [DATA_W-1:0] imm_sx, rf_qa, rf_qb, rf_wd;
   logic [RA_W-1:0]   rf_wa;
   logic              pc_load;
   logic [DATA_W-MEM_AW-3:0] unused_addr_hi;
   logic [1:0]               unused_addr_lo;

   assign imm_sx = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

   // operand selection
   assign opa = opa_sel ? a_q : pc_q;
   always_comb begin
      case (opb_sel)
         OPB_REG:   opb = b_q;
         OPB_FOUR:  opb = DATA_W'(4);
         OPB_IMM:   opb = imm_sx;
         default:   opb = {imm_sx[DATA_W-3:0], 2'b00};
      endcase
   end

   mc_alu #(.W(DATA_W), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .a(opa), .b(opb), .op(alu_op), .res(alu_res), .zero(alu_zero)
   );

   // shared memory
   assign mem_addr       = addr_sel ? aluout_q : pc_q;
   assign unused_addr_hi = mem_addr[DATA_W-1:MEM_AW+2];
   assign unused_addr_lo = mem_addr[1:0];

   mc_memory #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .idx(mem_addr[MEM_AW+1:2]), .we(mem_wr), .wd(b_q), .rd(mem_rd),
      .pl_we(pl_we), .pl_idx(pl_idx), .pl_wd(pl_wdata), .pl_rd(pl_rdata)
   );

   // register file
   assign rf_wa = rf_dst_sel ? ir_q[15:11] : ir_q[20:16];
   assign rf_wd = wb_sel ? mdr_q : aluout_q;

   mc_regfile #(.W(DATA_W), .N(REGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra(ir_q[25:21]), .rb(ir_q[20:16]),
      .we(rf_wr), .wa(rf_wa), .wd(rf_wd),
      .qa(rf_qa), .qb(rf_qb)
   );

   // next program counter
   always_comb begin
      case (npc_sel)
         NPC_HELD: npc = aluout_q;
         NPC_JUMP: npc = {pc_q[DATA_W-1:28], ir_q[25:0], 2'b00};
         default:  npc = alu_res;
      endcase
   end
   assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= '0;
         ir_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         mdr_q    <= '0;
         aluout_q <= '0;
      end else begin
         if (pc_load) pc_q <= npc;
         if (ir_wr)   ir_q <= mem_rd;
         a_q      <= rf_qa;
         b_q      <= rf_qb;
         mdr_q    <= mem_rd;
         aluout_q <= alu_res;
      end
   end

   assign opcode = ir_q[31:26];
   assign funct  = ir_q[5:0];

   // R8
   pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));
   // R8
   pc_cond_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr && pc_wr_cond && !alu_zero) |=> $stable(pc_q));
   // R7
   pc_from_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && (npc_sel == NPC_ALU)) |=> (pc_q == $past(alu_res)));
   // R3
   ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_wr |=> $stable(ir_q));
   // R11
   mdr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (mdr_q == $past(mem_rd)));
endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/100ps
module mc_datapath_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, addr_sel, mem_wr, ir_wr, opa_sel, pc_wr, pc_wr_cond;
   logic rf_wr, rf_dst_sel, wb_sel, pl_we, alu_zero;
   logic [1:0] opb_sel, npc_sel;
   logic [2:0] alu_op;
   logic [5:0] pl_idx, opcode, funct;
   logic [31:0] pl_wdata, pl_rdata;

   mc_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .mem_wr(mem_wr),
      .ir_wr(ir_wr), .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_op(alu_op),
      .npc_sel(npc_sel), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .wb_sel(wb_sel),
      .pl_we(pl_we), .pl_idx(pl_idx), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata),
      .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [31:0] exp_pc;
   logic [31:0] mr [32];
   logic [31:0] dm [64];
   logic zero_s;
   localparam int SCR = 50;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      addr_sel = 0; mem_wr = 0; ir_wr = 0; opa_sel = 0; opb_sel = 0; alu_op = 0;
      npc_sel = 0; pc_wr = 0; pc_wr_cond = 0; rf_wr = 0; rf_dst_sel = 0;
      wb_sel = 0; pl_we = 0;
   endtask

   task automatic cyc();
      #1 zero_s = alu_zero;
      @(negedge clk);
   endtask

   function automatic logic [31:0] alu_model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return {31'd0, $signed(a) < $signed(b)};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic place(input int idx, input logic [31:0] w);
      idle(); pl_we = 1; pl_idx = 6'(idx); pl_wdata = w;
      cyc();
      pl_we = 0;
      dm[idx] = w;
   endtask

   task automatic peek(input int idx, input logic [31:0] exp, input string req);
      pl_idx = 6'(idx);
      #0.5 chk(pl_rdata == exp, req, pl_rdata, exp);
   endtask

   // R3 R7: fetch places a word at the expected PC; PC advances by the live sum
   task automatic raw_fetch(input logic [31:0] w, input string req);
      place(int'(exp_pc[7:2]), w);
      idle(); ir_wr = 1; pc_wr = 1; opb_sel = 2'd1; npc_sel = 2'd0;
      cyc();
      exp_pc = exp_pc + 4;
      chk({opcode, funct} == {w[31:26], w[5:0]}, req, {20'd0, opcode, funct}, {20'd0, w[31:26], w[5:0]});
   endtask

   task automatic probe(input string req);
      raw_fetch(itype(6'h3E, 5'd0, 5'd0, {10'd0, exp_pc[7:2]}), req);
   endtask

   task automatic decode();
      idle(); opb_sel = 2'd3;
      cyc();
   endtask

   task automatic do_jump(input int tw);
      raw_fetch({6'h02, 26'(tw)}, "R3 jump fetch");
      decode();
      idle(); pc_wr = 1; npc_sel = 2'd2;
      cyc();
      exp_pc = {exp_pc[31:28], 26'(tw), 2'b00};
      probe("R7 jump target");
   endtask

   task automatic fetch(input logic [31:0] w);
      if (exp_pc >= 96) do_jump(0);
      raw_fetch(w, "R3 fetch");
   endtask

   task automatic do_lw(input int rt, input int rs, input logic [15:0] imm);
      logic [31:0] ea;
      fetch(itype(6'h23, 5'(rs), 5'(rt), imm));
      decode();
      idle(); opa_sel = 1; opb_sel = 2'd2;
      cyc();
      ea = mr[rs] + {{16{imm[15]}}, imm};
      idle(); addr_sel = 1;
      cyc();
      // R3: data read with ir_wr low leaves the instruction in place
      chk(opcode == 6'h23, "R3 hold", {26'd0, opcode}, 32'h23);
      idle(); rf_wr = 1; rf_dst_sel = 0; wb_sel = 1;
      cyc();
      if (rt != 0) mr[rt] = dm[ea[7:2]];
   endtask

   task automatic sw_front(input int rt, input int rs, input logic [15:0] imm);
      fetch(itype(6'h2B, 5'(rs), 5'(rt), imm));
      decode();
      idle(); opa_sel = 1; opb_sel = 2'd2;
      cyc();
      idle(); addr_sel = 1; mem_wr = 1;
   endtask

   task automatic check_reg(input int r, input string req);
      sw_front(r, 0, 16'(SCR * 4));
      cyc();
      dm[SCR] = mr[r];
      peek(SCR, mr[r], req);
   endtask

   task automatic do_r(input int rs, input int rt, input int rd, input logic [2:0] op);
      logic [31:0] res;
      fetch({6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 3'b100, op});
      decode();
      idle(); opa_sel = 1; opb_sel = 2'd0; alu_op = op;
      cyc();
      res = alu_model(op, mr[rs], mr[rt]);
      chk(zero_s == (res == 0), "R6 zero flag", {31'd0, zero_s}, {31'd0, res == 0});
      idle(); rf_wr = 1; rf_dst_sel = 1; wb_sel = 0;
      cyc();
      if (rd != 0) mr[rd] = res;
   endtask

   task automatic do_beq(input int rs, input int rt, input logic [15:0] off);
      logic [31:0] tgt;
      logic eq;
      fetch(itype(6'h04, 5'(rs), 5'(rt), off));
      decode();
      tgt = exp_pc + {{14{off[15]}}, off, 2'b00};
      eq  = (mr[rs] == mr[rt]);
      idle(); opa_sel = 1; opb_sel = 2'd0; alu_op = 3'd1; npc_sel = 2'd1; pc_wr_cond = 1;
      cyc();
      chk(zero_s == eq, "R8 compare", {31'd0, zero_s}, {31'd0, eq});
      if (eq) exp_pc = tgt;
      probe(eq ? "R8 branch taken" : "R8 branch not taken");
   endtask

   logic [31:0] vals [6];

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
      vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
      for (int i = 0; i < 32; i++) mr[i] = 0;
      for (int i = 0; i < 64; i++) dm[i] = 0;
      idle(); pl_idx = 0; pl_wdata = 0; rst_n = 0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rst_n = 1;
      exp_pc = 0;
      // R1
      chk({opcode, funct} == 12'd0, "R1 reset ir", {20'd0, opcode, funct}, 32'd0);
      probe("R1 reset pc");
      for (int i = 0; i < 6; i++) place(40 + i, vals[i]);

      // R2 R5 R11: loads from a positive immediate, register 0 base
      do_lw(7, 0, 16'd164);
      check_reg(7, "R2 load");
      // R5 negative offset through sign extension
      place(54, 32'd228);
      place(55, 32'hCAFE_0001);
      do_lw(4, 0, 16'd216);
      do_lw(5, 4, 16'hFFF8);
      check_reg(5, "R5 negative offset");

      // R10
      do_lw(0, 0, 16'd164);
      check_reg(0, "R10 load to r0");
      do_r(7, 7, 0, 3'd0);
      check_reg(0, "R10 alu to r0");

      // R4 R5 R6 R9 sweep
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            do_lw(1, 0, 16'(160 + 4 * i));
            do_lw(2, 0, 16'(160 + 4 * j));
            for (int op = 0; op < 8; op++) begin
               if (op == 5 || op == 6) continue;
               do_r(1, 2, 3, 3'(op));
               check_reg(3, "R6 alu result");
            end
         end
      end

      // R8 branches
      do_lw(1, 0, 16'd164);
      do_lw(2, 0, 16'd164);
      do_lw(6, 0, 16'd168);
      do_beq(1, 2, 16'd3);
      do_beq(1, 6, 16'd3);
      do_beq(2, 1, 16'hFFFB);
      do_beq(6, 1, 16'hFFFD);
      // R7 jump to a nonzero word
      do_jump(5);

      // R12 side port beats a datapath store to the same word
      sw_front(6, 0, 16'(SCR * 4));
      pl_we = 1; pl_idx = 6'(SCR); pl_wdata = 32'hA5A5_0F0F;
      cyc();
      pl_we = 0;
      peek(SCR, 32'hA5A5_0F0F, "R12 priority");

      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule